// File: doc/BRIEF.md
# Prioritized DMA Bus Arbiter with Freeze

This block decides which of up to sixteen DMA channels may drive one shared bus port. Every channel raises a request line and carries a 3-bit priority value. Among the channels that request at the same time, the one with the largest value gets the port. Once a channel holds the grant, it keeps it until it pulses `unit_done`. That pulse marks the end of a single unit or of a whole burst, and arbitration runs again only at that point.

A channel whose `hold_en` bit is set works in blocking mode. If it still requests when it finishes a unit, it keeps the port for the next unit, and every other channel waits, including one with a higher priority.

The `freeze` input stops all new grants and keeps pending requests intact. Freeze never cuts a unit or burst that is in progress. It takes effect at the next `unit_done`. When freeze is released, arbitration resumes from the requests that are present at that time.

The controller has three states:
- IDLE: no grant is issued.
- GRANT: one channel owns the port.
- FROZEN: no grant may be issued.

Its transitions are:
- IDLE→GRANT, on a request while not frozen.
- IDLE→FROZEN, on freeze.
- GRANT→GRANT, on a unit boundary that either keeps the owner (blocking) or hands the port to the next winner.
- GRANT→IDLE, on a unit boundary with no requester left.
- GRANT→FROZEN, on a unit boundary while freeze is high.
- FROZEN→IDLE, on release.

Top module: `dma_bus_arbiter`

## Requirements
- R1: Out of reset, and whenever no grant is held and no channel requests, `gnt` is all zero and `gnt_valid` is low in the following cycle.
- R2: From IDLE, the requesting channel with the greatest priority value (field `ch_prio[3*i+2:3*i]` for channel i, 0 lowest, 7 highest) is granted one clock edge after its request is sampled.
- R3: Among requesting channels with equal priority, the lowest channel index is granted.
- R4: `gnt` is one-hot or zero, and `gnt_valid` is high exactly when one bit of `gnt` is set.
- R5: A held grant does not change while `unit_done` is low, even when a channel of higher priority starts to request.
- R6: On a `unit_done` edge with `freeze` low and no blocking hold, the port passes directly to the winner among the requests sampled at that edge, with no empty cycle. With no requester left, the grant drops.
- R7: If the owner has `hold_en` set and its request is still high at `unit_done`, it keeps the grant, whatever the priority of the other requesters.
- R8: While `freeze` is high and no grant is held, no grant is issued. After `freeze` is sampled low, a pending request is granted at the second clock edge.
- R9: Raising `freeze` while a grant is held does not remove it before `unit_done`. At `unit_done` with `freeze` high, the grant drops even for a blocking owner.
- R10: `unit_done` has no effect when no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | NUM_CH | Request line per channel |
| ch_prio | input | NUM_CH*PRIO_W | Packed 3-bit priority per channel |
| hold_en | input | NUM_CH | Blocking-mode enable per channel |
| freeze | input | 1 | Global suspend of new grants |
| unit_done | input | 1 | Owner finished its current unit or burst |
| gnt | output | NUM_CH | One-hot grant vector |
| gnt_valid | output | 1 | A grant is held |

## Verification
Two pairs of functions can land on the same edge.

The first pair is the end of a unit and a freeze request. The bench raises `freeze` while a grant is held and later pulses `unit_done` with `freeze` still high. A reference model must see the grant kept through the freeze and dropped exactly at the boundary.

The second pair is a blocking hold and freeze at the same boundary. Here the owner keeps its request and has `hold_en` set, and the scoreboard expects freeze to win, with an empty grant.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GRANT  = 2'd1,
        ST_FROZEN = 2'd2
    } arb_state_e;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]         win_idx,
    output logic                     win_found
);
    logic [PRIO_W-1:0] best;

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        best      = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i] && (!win_found || prio[i*PRIO_W +: PRIO_W] >= best)) begin
                win_found = 1'b1;
                best      = prio[i*PRIO_W +: PRIO_W];
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dma_grant_fsm.sv
module dma_grant_fsm
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] hold_en,
    input  logic              freeze,
    input  logic              unit_done,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              win_found,
    output logic [NUM_CH-1:0] gnt,
    output logic              gnt_valid
);
    arb_state_e       state, nxt_state;
    logic [IDX_W-1:0] owner, nxt_owner;

    always_comb begin
        nxt_state = state;
        nxt_owner = owner;
        unique case (state)
            ST_IDLE: begin
                if (freeze) begin
                    nxt_state = ST_FROZEN;
                end else if (win_found) begin
                    nxt_state = ST_GRANT;
                    nxt_owner = win_idx;
                end
            end
            ST_GRANT: begin
                if (unit_done) begin
                    if (freeze) begin
                        nxt_state = ST_FROZEN;
                    end else if (hold_en[owner] && req[owner]) begin
                        nxt_state = ST_GRANT;
                    end else if (win_found) begin
                        nxt_owner = win_idx;
                    end else begin
                        nxt_state = ST_IDLE;
                    end
                end
            end
            ST_FROZEN: begin
                if (!freeze) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            owner <= '0;
        end else begin
            state <= nxt_state;
            owner <= nxt_owner;
        end
    end

    // Outputs
    always_comb begin
        gnt_valid = (state == ST_GRANT);
        gnt       = '0;
        if (state == ST_GRANT) gnt[owner] = 1'b1;
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt) && (gnt_valid == (gnt != '0))); // R4
    AST_IDLE_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && req == '0) |=> !gnt_valid); // R1
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && !unit_done) |=> (gnt_valid && $stable(gnt))); // R5
    AST_BLOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && unit_done && !freeze && ((gnt & hold_en & req) != '0))
        |=> (gnt_valid && $stable(gnt))); // R7
    AST_FREEZE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !gnt_valid) |=> !gnt_valid); // R8
    AST_FREEZE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_valid && unit_done && freeze) |=> !gnt_valid); // R9
endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
    parameter int NUM_CH = 16,
    parameter int PRIO_W = 3,
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_req,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic [NUM_CH-1:0]        hold_en,
    input  logic                     freeze,
    input  logic                     unit_done,
    output logic [NUM_CH-1:0]        gnt,
    output logic                     gnt_valid
);
    logic [IDX_W-1:0] win_idx;
    logic             win_found;

    dma_prio_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick (
        .req       (ch_req),
        .prio      (ch_prio),
        .win_idx   (win_idx),
        .win_found (win_found)
    );

    dma_grant_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ch_req),
        .hold_en   (hold_en),
        .freeze    (freeze),
        .unit_done (unit_done),
        .win_idx   (win_idx),
        .win_found (win_found),
        .gnt       (gnt),
        .gnt_valid (gnt_valid)
    );

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_valid && unit_done && ch_req == '0) |=> !gnt_valid); // R10
endmodule

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;
    localparam int N  = 16;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ch_req = '0;
    logic [N*PW-1:0] ch_prio = '0;
    logic [N-1:0]  hold_en = '0;
    logic          freeze = 1'b0;
    logic          unit_done = 1'b0;
    logic [N-1:0]  gnt;
    logic          gnt_valid;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [N-1:0] g;
        string        tag;
    } exp_t;
    exp_t sb_q[$];

    // reference model state
    logic   m_valid = 1'b0;
    logic   m_frozen = 1'b0;
    int     m_owner = 0;

    always #2.5 clk = ~clk;

    dma_bus_arbiter #(.NUM_CH(N), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_prio(ch_prio),
        .hold_en(hold_en), .freeze(freeze), .unit_done(unit_done),
        .gnt(gnt), .gnt_valid(gnt_valid)
    );

    function automatic int ref_pick(input logic [N-1:0] r);
        int best_i = -1;
        int best_p = -1;
        for (int i = 0; i < N; i++) begin
            if (r[i] && int'(ch_prio[i*PW +: PW]) > best_p) begin
                best_p = int'(ch_prio[i*PW +: PW]);
                best_i = i;
            end
        end
        return best_i;
    endfunction

    task automatic set_prio(input int ch, input int p);
        ch_prio[ch*PW +: PW] = PW'(p);
    endtask

    // Driver: apply one cycle of stimulus and push the expected grant.
    task automatic step(input logic [N-1:0] r, input logic d, input logic f, input string tag);
        int w;
        exp_t e;
        @(negedge clk);
        ch_req = r; unit_done = d; freeze = f;
        w = ref_pick(r);
        if (m_frozen) begin
            if (!f) m_frozen = 1'b0;
        end else if (!m_valid) begin
            if (f) m_frozen = 1'b1;
            else if (w >= 0) begin m_valid = 1'b1; m_owner = w; end
        end else if (d) begin
            if (f) begin m_valid = 1'b0; m_frozen = 1'b1; end
            else if (hold_en[m_owner] && r[m_owner]) m_valid = 1'b1;
            else if (w >= 0) m_owner = w;
            else m_valid = 1'b0;
        end
        e.g = m_valid ? (N'(1) << m_owner) : '0;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (gnt !== e.g || gnt_valid !== (e.g != '0)) begin
                    errors++;
                    $display("FAIL %s: gnt=%h valid=%b expected gnt=%h valid=%b",
                             e.tag, gnt, gnt_valid, e.g, (e.g != '0));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_prio(3, 2); set_prio(7, 5); set_prio(1, 7);
        set_prio(4, 6); set_prio(9, 6); set_prio(2, 1); set_prio(10, 7);
        set_prio(12, 3);
        repeat (3) @(negedge clk);
        checks++;
        if (gnt !== '0 || gnt_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: gnt=%h valid=%b expected gnt=0 valid=0", gnt, gnt_valid);
        end
        rst_n = 1'b1;

        // R1: quiet bus, R10: stray done
        step('0, 1'b0, 1'b0, "R1 idle");
        step('0, 1'b1, 1'b0, "R10 done ignored");
        step('0, 1'b0, 1'b0, "R1 idle");
        // R2: ch7 (prio 5) beats ch3 (prio 2)
        step(16'h0088, 1'b0, 1'b0, "R2 priority");
        // R5: ch1 (prio 7) arrives but cannot preempt
        step(16'h008A, 1'b0, 1'b0, "R5 no preempt");
        step(16'h008A, 1'b0, 1'b0, "R5 no preempt");
        // R6: ch7 done and drops request -> ch1 with no gap
        step(16'h000A, 1'b1, 1'b0, "R6 handover");
        step(16'h0008, 1'b1, 1'b0, "R6 handover low");
        step(16'h0000, 1'b1, 1'b0, "R6 drop");
        // R3: ch4 and ch9 tie at prio 6
        step(16'h0210, 1'b0, 1'b0, "R3 tie");
        step(16'h0000, 1'b1, 1'b0, "R6 drop");
        // R7: blocking ch2 keeps bus despite ch10 prio 7
        hold_en[2] = 1'b1;
        step(16'h0004, 1'b0, 1'b0, "R2 single");
        step(16'h0404, 1'b1, 1'b0, "R7 blocking hold");
        step(16'h0404, 1'b1, 1'b0, "R7 blocking hold");
        step(16'h0400, 1'b1, 1'b0, "R7 release");
        step(16'h0000, 1'b1, 1'b0, "R6 drop");
        // R8: freeze while idle
        step(16'h1000, 1'b0, 1'b1, "R8 frozen idle");
        step(16'h1000, 1'b0, 1'b1, "R8 frozen idle");
        step(16'h1000, 1'b1, 1'b1, "R10 done in freeze");
        step(16'h1000, 1'b0, 1'b0, "R8 release edge");
        step(16'h1000, 1'b0, 1'b0, "R8 resume grant");
        step(16'h0000, 1'b1, 1'b0, "R6 drop");
        // R9: freeze during grant, done with freeze
        step(16'h0080, 1'b0, 1'b0, "R2 grant");
        step(16'h0080, 1'b0, 1'b1, "R9 grant survives freeze");
        step(16'h0080, 1'b0, 1'b1, "R9 grant survives freeze");
        step(16'h0080, 1'b1, 1'b1, "R9 drop at boundary");
        step(16'h0080, 1'b0, 1'b0, "R8 release edge");
        step(16'h0080, 1'b0, 1'b0, "R8 resume grant");
        step(16'h0000, 1'b1, 1'b0, "R6 drop");
        // R9 vs R7: freeze beats blocking hold at the same boundary
        step(16'h0004, 1'b0, 1'b0, "R2 grant");
        step(16'h0404, 1'b1, 1'b1, "R9 freeze beats hold");
        step(16'h0404, 1'b0, 1'b1, "R8 frozen");
        step(16'h0404, 1'b0, 1'b0, "R8 release edge");
        step(16'h0404, 1'b0, 1'b0, "R2 ch10 wins");
        step(16'h0000, 1'b1, 1'b0, "R1 drop");
        step(16'h0000, 1'b0, 1'b0, "R1 idle");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule